// File: doc/BRIEF.md
# Set-Associative Read Cache with LRU Replacement

This block is a read-only cache in front of a slow word-wide memory. Its geometry comes from three parameters: the number of ways, the number of sets and the block size in bytes. With one way it is a direct-mapped cache. With one set it is fully associative. Any other mix gives an N-way set-associative cache. A 32-bit byte address is split into a tag, a set index and a byte offset. All ways of the selected set are compared in parallel. On a hit the addressed word comes back one cycle after the request is taken.

On a miss the cache raises `stall` and fetches the whole block over a request/acknowledge memory port, one word per beat, starting at the lowest word. It fills the lowest-numbered invalid way of the set. If every way is valid, it evicts the way that has gone longest without an access. Each set keeps one age counter per way. A hit or a fill makes that way the youngest, and only the ways that were younger than it grow one step older. Each response states whether the access hit or missed.

Top module: `assoc_cache`

## Requirements
- R1: The byte offset is the low log2(BLOCK_BYTES) address bits. The set is the block number (address divided by BLOCK_BYTES) modulo SETS. The tag is all remaining upper bits. Two addresses in the same block share one entry, and two blocks with equal set index and different tags compete for the ways of that set.
- R2: A request is taken on a rising edge where `req_valid` is high and `stall` is low. If some way of the selected set is valid and holds the tag, then on the next cycle `rsp_valid` is high, `rsp_hit` is 1, `rsp_data` is the addressed word, and `stall` stays low.
- R3: On a miss, `stall` and `mem_req` are high from the cycle after the request is taken until the fill ends. `mem_addr` starts at the block base (offset bits zero) and rises by 4 after each acknowledged beat. Each beat with `mem_ack` high delivers one 32-bit word on `mem_rdata`.
- R4: The fill ends on the beat that delivers the last word. On the next cycle `rsp_valid` is high with `rsp_hit` 0 and the requested word, and `stall` is low. A later access to any word of that block hits.
- R5: A miss goes into an invalid way while the set has one, taking the lowest-numbered way first. No valid block is evicted until every way of the set is valid.
- R6: With every way valid, a miss evicts the least recently used way of the set. Both hits and fills count as uses.
- R7: After reset no entry is valid, and `rsp_valid`, `stall` and `mem_req` are low.
- R8: With WAYS=1, two blocks that map to the same set evict each other on every access. Blocks in other sets are unaffected.
- R9: With SETS=1, any block can use any way. A block is evicted only by capacity, under the LRU rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the read |
| stall | output | 1 | Fill in progress, requests not taken |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 for a hit, 0 for a miss |
| rsp_data | output | 32 | Addressed word |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Memory beat acknowledge, data valid |
| mem_rdata | input | 32 | Memory word for the acknowledged beat |

## Verification
The bench builds three copies side by side. The first has 2 ways, 2 sets and 8-byte blocks, which exercises the word select inside a two-word block, a set conflict and eviction within one set. The second has 4 ways, 1 set and 4-byte blocks. This is the fully associative corner with a single word per block and a zero-width set field, where the LRU order across four ways is visible through hit patterns. The third has 1 way, 4 sets and 8-byte blocks, which reaches the direct-mapped corner where two blocks thrash a single entry.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

  typedef enum logic [0:0] {
    ST_LOOKUP = 1'b0,
    ST_FILL   = 1'b1
  } cache_state_e;

  // Width needed to index n items, at least one bit.
  function automatic int bits_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Tag width for a 32-bit byte address.
  function automatic int tag_bits(input int sets, input int block_bytes);
    return 32 - $clog2(block_bytes) - $clog2(sets);
  endfunction

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split
  import assoc_cache_pkg::*;
#(
  parameter int SETS        = 4,
  parameter int BLOCK_BYTES = 16
) (
  input  logic [31:0]                               addr,
  output logic [tag_bits(SETS, BLOCK_BYTES)-1:0]    tag,
  output logic [bits_of(SETS)-1:0]                  set_idx,
  output logic [bits_of(BLOCK_BYTES/4)-1:0]         word_idx
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int TAG_W  = tag_bits(SETS, BLOCK_BYTES);
  localparam int IDX_W  = bits_of(SETS);
  localparam int WORDS  = BLOCK_BYTES / 4;
  localparam int WORD_W = bits_of(WORDS);

  logic [31:0] block_num;

  assign block_num = addr >> OFF_W;
  assign set_idx   = IDX_W'(block_num % 32'(SETS));
  assign tag       = addr[31 -: TAG_W];

  generate
    if (WORDS > 1) begin : g_multi_word
      assign word_idx = addr[OFF_W-1:2];
    end else begin : g_single_word
      assign word_idx = '0;
    end
  endgenerate

endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match
  import assoc_cache_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            tag,
  output logic [WAYS-1:0]             way_match,
  output logic                        hit,
  output logic [bits_of(WAYS)-1:0]    hit_way,
  output logic                        any_free,
  output logic [bits_of(WAYS)-1:0]    free_way
);
  localparam int WAY_W = bits_of(WAYS);

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign way_match[w] = valid[w] && (tags[w] == tag);
    end
  endgenerate

  assign hit      = |way_match;
  assign any_free = ~&valid;

  // Scan from the top so the lowest index wins.
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_match[w]) hit_way  = WAY_W'(w);
      if (!valid[w])    free_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/cache_lru.sv
module cache_lru
  import assoc_cache_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 4
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      touch,
  input  logic [bits_of(SETS)-1:0]  touch_set,
  input  logic [bits_of(WAYS)-1:0]  touch_way,
  input  logic [bits_of(SETS)-1:0]  rd_set,
  output logic [bits_of(WAYS)-1:0]  victim
);
  localparam int WAY_W = bits_of(WAYS);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q, age_d;
  logic [WAYS-1:0]                      is_oldest;

  always_comb begin
    age_d = age_q;
    if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) begin
          age_d[touch_set][w] = '0;
        end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
          age_d[touch_set][w] = age_q[touch_set][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    victim = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      is_oldest[w] = (age_q[rd_set][w] == OLDEST);
      if (is_oldest[w]) victim = WAY_W'(w);
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot(is_oldest)); // R6

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
  import assoc_cache_pkg::*;
#(
  parameter int WAYS        = 4,
  parameter int SETS        = 4,
  parameter int BLOCK_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        stall,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [31:0] rsp_data,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int WORDS  = BLOCK_BYTES / 4;
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int WAY_W  = bits_of(WAYS);
  localparam int IDX_W  = bits_of(SETS);
  localparam int WORD_W = bits_of(WORDS);
  localparam int TAG_W  = tag_bits(SETS, BLOCK_BYTES);
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  cache_state_e                      state_q, state_d;
  logic [SETS-1:0][WAYS-1:0]         valid_q, valid_d;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [31:0]                       data_q [SETS][WAYS][WORDS];

  logic [IDX_W-1:0]  fill_set_q,  fill_set_d;
  logic [WAY_W-1:0]  fill_way_q,  fill_way_d;
  logic [TAG_W-1:0]  fill_tag_q,  fill_tag_d;
  logic [WORD_W-1:0] fill_word_q, fill_word_d;
  logic [WORD_W-1:0] beat_q,      beat_d;
  logic [31:0]       fill_base_q, fill_base_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_hit_q,   rsp_hit_d;
  logic [31:0]       rsp_data_q,  rsp_data_d;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_set;
  logic [WORD_W-1:0] req_word;
  logic [WAYS-1:0]   way_match;
  logic              hit, any_free;
  logic [WAY_W-1:0]  hit_way, free_way, victim;
  logic              touch;
  logic [IDX_W-1:0]  touch_set;
  logic [WAY_W-1:0]  touch_way;
  logic              accept, fill_ack, fill_last;

  cache_addr_split #(.SETS(SETS), .BLOCK_BYTES(BLOCK_BYTES)) u_split (
    .addr     (req_addr),
    .tag      (req_tag),
    .set_idx  (req_set),
    .word_idx (req_word)
  );

  cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid     (valid_q[req_set]),
    .tags      (tag_q[req_set]),
    .tag       (req_tag),
    .way_match (way_match),
    .hit       (hit),
    .hit_way   (hit_way),
    .any_free  (any_free),
    .free_way  (free_way)
  );

  cache_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .touch     (touch),
    .touch_set (touch_set),
    .touch_way (touch_way),
    .rd_set    (req_set),
    .victim    (victim)
  );

  assign accept    = (state_q == ST_LOOKUP) && req_valid;
  assign fill_ack  = (state_q == ST_FILL) && mem_ack;
  assign fill_last = fill_ack && (beat_q == LAST_BEAT);

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    valid_d     = valid_q;
    fill_set_d  = fill_set_q;
    fill_way_d  = fill_way_q;
    fill_tag_d  = fill_tag_q;
    fill_word_d = fill_word_q;
    beat_d      = beat_q;
    fill_base_d = fill_base_q;
    rsp_valid_d = 1'b0;
    rsp_hit_d   = rsp_hit_q;
    rsp_data_d  = rsp_data_q;
    touch       = 1'b0;
    touch_set   = req_set;
    touch_way   = hit_way;
    unique case (state_q)
      ST_LOOKUP: begin
        if (accept) begin
          if (hit) begin
            rsp_valid_d = 1'b1;
            rsp_hit_d   = 1'b1;
            rsp_data_d  = data_q[req_set][hit_way][req_word];
            touch       = 1'b1;
          end else begin
            state_d     = ST_FILL;
            fill_set_d  = req_set;
            fill_way_d  = any_free ? free_way : victim;
            fill_tag_d  = req_tag;
            fill_word_d = req_word;
            fill_base_d = {req_addr[31:OFF_W], {OFF_W{1'b0}}};
            beat_d      = '0;
          end
        end
      end
      ST_FILL: begin
        if (fill_ack) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == fill_word_q) rsp_data_d = mem_rdata;
          if (fill_last) begin
            state_d                        = ST_LOOKUP;
            valid_d[fill_set_q][fill_way_q] = 1'b1;
            rsp_valid_d                    = 1'b1;
            rsp_hit_d                      = 1'b0;
            touch                          = 1'b1;
            touch_set                      = fill_set_q;
            touch_way                      = fill_way_q;
          end
        end
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_LOOKUP;
      valid_q     <= '0;
      fill_set_q  <= '0;
      fill_way_q  <= '0;
      fill_tag_q  <= '0;
      fill_word_q <= '0;
      beat_q      <= '0;
      fill_base_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      valid_q     <= valid_d;
      fill_set_q  <= fill_set_d;
      fill_way_q  <= fill_way_d;
      fill_tag_q  <= fill_tag_d;
      fill_word_q <= fill_word_d;
      beat_q      <= beat_d;
      fill_base_q <= fill_base_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  // Storage arrays, written only during a fill
  always_ff @(posedge clk) begin
    if (fill_ack)  data_q[fill_set_q][fill_way_q][beat_q] <= mem_rdata;
    if (fill_last) tag_q[fill_set_q][fill_way_q]          <= fill_tag_q;
  end

  assign stall     = (state_q == ST_FILL);
  assign mem_req   = (state_q == ST_FILL);
  assign mem_addr  = fill_base_q + (32'(beat_q) << 2);
  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;

  AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_LOOKUP) |-> $onehot0(way_match)); // R2
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_hit) |-> !stall); // R2
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (fill_ack && !fill_last) |=> (mem_req && mem_addr == $past(mem_addr) + 32'd4)); // R3
  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(stall) |-> (rsp_valid && !rsp_hit)); // R4
  AST_FREE_WAY_USED: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && !hit && any_free) |=> !valid_q[fill_set_q][fill_way_q]); // R5

endmodule

// File: tb/assoc_cache_test.sv
module assoc_cache_test;

  typedef struct {
    int          cfg;
    bit          hit;
    logic [31:0] data;
  } exp_item_t;

  logic        clk;
  logic        rst_n;
  logic [2:0]  req_valid;
  logic [31:0] req_addr [3];
  logic [2:0]  stall, rsp_valid, rsp_hit, mem_req, mem_ack;
  logic [31:0] rsp_data [3];
  logic [31:0] mem_addr [3];
  logic [31:0] mem_rdata [3];

  int n_checks = 0;
  int n_fail   = 0;
  int issued   = 0;
  int seen     = 0;
  exp_item_t sb_q[$];

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return (a & 32'hFFFF_FFFC) * 32'd7 + 32'h1234_0000;
  endfunction

  function automatic logic [31:0] block_bytes(input int c);
    return (c == 1) ? 32'd4 : 32'd8;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // c0: 2 ways, 2 sets, 8-byte blocks
  assoc_cache #(.WAYS(2), .SETS(2), .BLOCK_BYTES(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_addr(req_addr[0]),
    .stall(stall[0]), .rsp_valid(rsp_valid[0]), .rsp_hit(rsp_hit[0]), .rsp_data(rsp_data[0]),
    .mem_req(mem_req[0]), .mem_addr(mem_addr[0]), .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]));

  // c1: 4 ways, 1 set, 4-byte blocks
  assoc_cache #(.WAYS(4), .SETS(1), .BLOCK_BYTES(4)) uut_fa (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_addr(req_addr[1]),
    .stall(stall[1]), .rsp_valid(rsp_valid[1]), .rsp_hit(rsp_hit[1]), .rsp_data(rsp_data[1]),
    .mem_req(mem_req[1]), .mem_addr(mem_addr[1]), .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]));

  // c2: 1 way, 4 sets, 8-byte blocks
  assoc_cache #(.WAYS(1), .SETS(4), .BLOCK_BYTES(8)) uut_dm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[2]), .req_addr(req_addr[2]),
    .stall(stall[2]), .rsp_valid(rsp_valid[2]), .rsp_hit(rsp_hit[2]), .rsp_data(rsp_data[2]),
    .mem_req(mem_req[2]), .mem_addr(mem_addr[2]), .mem_ack(mem_ack[2]), .mem_rdata(mem_rdata[2]));

  // Memory model: one beat every other cycle, driven away from the active edge.
  always @(negedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (!rst_n) begin
        mem_ack[c] <= 1'b0;
      end else begin
        mem_ack[c] <= mem_req[c] && !mem_ack[c];
      end
      mem_rdata[c] <= mem_fn(mem_addr[c]);
    end
  end

  // Monitor: pop and compare each response.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 3; c++) begin
        if (rsp_valid[c]) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R2", "unexpected response", 32'(c), 32'hFFFF_FFFF);
          end else begin
            exp_item_t it;
            it = sb_q.pop_front();
            check(it.cfg == c, it.hit ? "R2" : "R4", "responding config", 32'(c), 32'(it.cfg));
            check(rsp_hit[c] == it.hit, it.hit ? "R2" : "R4", "hit flag",
                  32'(rsp_hit[c]), 32'(it.hit));
            check(rsp_data[c] === it.data, it.hit ? "R2" : "R4", "data",
                  rsp_data[c], it.data);
          end
          seen++;
        end
      end
    end
  end

  // Driver: issue one access and queue its expected response.
  task automatic access(input int c, input logic [31:0] a, input bit exp_hit, input string req);
    exp_item_t it;
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_addr[c]  = a;
    it.cfg  = c;
    it.hit  = exp_hit;
    it.data = mem_fn(a);
    sb_q.push_back(it);
    issued++;
    @(negedge clk);
    req_valid[c] = 1'b0;
    if (exp_hit) begin
      check(!stall[c], req, "no stall on hit", 32'(stall[c]), 32'd0);
    end else begin
      check(stall[c] && mem_req[c], "R3", "stall and mem_req on miss",
            32'({stall[c], mem_req[c]}), 32'd3);
      check(mem_addr[c] == (a & ~(block_bytes(c) - 32'd1)), "R3", "first beat address",
            mem_addr[c], a & ~(block_bytes(c) - 32'd1));
    end
    wait (seen == issued);
    if (!exp_hit) begin
      check(!stall[c], "R4", "stall low after fill", 32'(stall[c]), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = '0;
    for (int c = 0; c < 3; c++) req_addr[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      check(!rsp_valid[c] && !stall[c] && !mem_req[c], "R7", "idle after reset",
            32'({rsp_valid[c], stall[c], mem_req[c]}), 32'd0);
    end

    // c0: 2-way, 2 sets, 8-byte blocks
    access(0, 32'd4,  1'b0, "R7");  // empty after reset
    access(0, 32'd0,  1'b1, "R1");  // other word, same block
    access(0, 32'd8,  1'b0, "R1");  // set 1
    access(0, 32'd36, 1'b0, "R5");  // set 0, free way used
    access(0, 32'd0,  1'b1, "R5");  // block 0 kept
    access(0, 32'd36, 1'b1, "R5");
    access(0, 32'd12, 1'b1, "R4");  // second word of block at 8
    access(0, 32'd16, 1'b0, "R6");  // evicts block 0 (LRU)
    access(0, 32'd36, 1'b1, "R6");
    access(0, 32'd0,  1'b0, "R6");  // evicts 16
    access(0, 32'd36, 1'b1, "R6");
    access(0, 32'd20, 1'b0, "R6");  // 16 was evicted

    // c1: fully associative, 4 ways
    access(1, 32'd0,  1'b0, "R9");
    access(1, 32'd4,  1'b0, "R9");
    access(1, 32'd8,  1'b0, "R9");
    access(1, 32'd12, 1'b0, "R9");
    access(1, 32'd4,  1'b1, "R5");
    access(1, 32'd16, 1'b0, "R6");  // evicts 0
    access(1, 32'd12, 1'b1, "R6");
    access(1, 32'd0,  1'b0, "R6");  // evicts 8
    access(1, 32'd4,  1'b1, "R6");
    access(1, 32'd16, 1'b1, "R9");
    access(1, 32'd8,  1'b0, "R6");  // evicts 12
    access(1, 32'd12, 1'b0, "R6");

    // c2: direct mapped, 4 sets
    access(2, 32'd0,  1'b0, "R8");
    access(2, 32'd32, 1'b0, "R8");  // same set 0
    access(2, 32'd0,  1'b0, "R8");
    access(2, 32'd36, 1'b0, "R8");
    access(2, 32'd4,  1'b0, "R8");
    access(2, 32'd0,  1'b1, "R8");
    access(2, 32'd8,  1'b0, "R8");  // set 1
    access(2, 32'd4,  1'b1, "R8");  // set 0 untouched

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2", "scoreboard drained", 32'(sb_q.size()), 32'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule